// File: doc/BRIEF.md
# Dual-Port Arbitrated RAM

This block is a synchronous two-port memory. Its default size is 4096 words of 8 bits. The left and right ports can each read or write any word on every clock. Each port has a chip enable, a write strobe, an address, write data and registered read data.

Both ports may enable and select the same word in the same cycle. The block then resolves the clash by granting that word to one of them. The other port sees its busy line high, and any write it attempts is dropped. Reads are never blocked. A read returns the word as it stood before any write made in the same cycle.

A mode input makes the block either a master or a slave, so that several instances can be placed side by side to build a wider word. As a master, the block drives its busy outputs from its own decision. As a slave, it takes busy from the master's outputs and uses them to block its own writes. Every slice of the wide word therefore obeys one decision.

Top module: `dual_port_arb_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (4096 x 8 with a 12-bit address by default). A port with ce high and we high writes its data at the clock edge unless it is busy. A port with ce high and we low loads that word into its read register at the edge. The read register holds its value at all other times. Reset clears both read registers to zero.
- R2: In master mode (master_i = 1) a busy output is high only when both ce inputs are high and the two addresses are equal.
- R3: In master mode, on contention exactly one busy output is high, and it belongs to the port that did not get the word.
- R4: If neither port, or both ports, had ce high on the same address in the previous cycle, the left port wins. If only one of them was already there, that port wins.
- R5: The winner keeps the grant for as long as it holds ce high on an unchanged address. After it drops ce or moves, the next contention is decided afresh.
- R6: In slave mode (master_i = 0) each busy output follows its busy input in the same cycle. A port whose busy input is high cannot write.
- R7: A write from a port whose busy output is high leaves the memory word unchanged.
- R8: A read that coincides with a write from the other port to the same word returns the word as it stood before that write.
- R9: In slave mode with both busy inputs low, two writes to the same word in one cycle leave the left port's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (drives busy), 0 = slave (takes busy) |
| l_ce_i | input | 1 | Left chip enable |
| l_we_i | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy from the master (slave mode) |
| l_busy_o | output | 1 | Left busy |
| l_rdata_o | output | DATA_W | Left registered read data |
| r_ce_i | input | 1 | Right chip enable |
| r_we_i | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy from the master (slave mode) |
| r_busy_o | output | 1 | Right busy |
| r_rdata_o | output | DATA_W | Right registered read data |

## Verification
The arbitration decision and the memory access share one cycle. The winner's write and the loser's access to the same word land on the same clock edge. The bench provokes this with a sweep over every address pair and every read/write combination of the two ports. A small 16-word configuration is used, and an idle cycle between accesses clears the grant. Each case is judged by the busy lines just before the edge and by the loser's registered read data after it. Later read-backs of every word confirm which write survived.

// File: rtl/dparb_pkg.sv
package dparb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dparb_arbiter.sv
module dparb_arbiter
  import dparb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              match_o,
  output logic              l_lose_o,
  output logic              r_lose_o
);
  logic              l_ce_q, r_ce_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  owner_e            own_q, win;
  logic              l_stay, r_stay, held;

  // a port "stays" when it was enabled on the same word last cycle
  assign l_stay  = l_ce_q && l_ce_i && (l_addr_q == l_addr_i);
  assign r_stay  = r_ce_q && r_ce_i && (r_addr_q == r_addr_i);
  assign match_o = l_ce_i && r_ce_i && (l_addr_i == r_addr_i);
  assign held    = ((own_q == OWN_LEFT) && l_stay) || ((own_q == OWN_RIGHT) && r_stay);

  always_comb begin
    if (held)                  win = own_q;
    else if (r_stay && !l_stay) win = OWN_RIGHT;
    else                       win = OWN_LEFT;
  end

  assign l_lose_o = match_o && (win == OWN_RIGHT);
  assign r_lose_o = match_o && (win == OWN_LEFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_ce_q   <= 1'b0;
      r_ce_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      own_q    <= OWN_NONE;
    end else begin
      l_ce_q   <= l_ce_i;
      r_ce_q   <= r_ce_i;
      l_addr_q <= l_addr_i;
      r_addr_q <= r_addr_i;
      own_q    <= match_o ? win : OWN_NONE;
    end
  end

  AST_FRESH_TIE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !l_stay && !r_stay) |-> !l_lose_o); // R4

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(match_o) && $past(r_lose_o) && l_stay && match_o) |-> r_lose_o); // R5
endmodule

// File: rtl/dparb_port_gate.sv
module dparb_port_gate (
  input  logic master_i,
  input  logic lose_i,
  input  logic busy_i,
  input  logic ce_i,
  input  logic we_i,
  output logic busy_o,
  output logic wr_en_o,
  output logic rd_en_o
);
  assign busy_o  = master_i ? lose_i : busy_i;
  assign wr_en_o = ce_i && we_i && !busy_o;
  assign rd_en_o = ce_i && !we_i;
endmodule

// File: rtl/dparb_mem.sv
module dparb_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wr_en_i,
  input  logic [1:0]        rd_en_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first so a same-word double write keeps the left data
  always_ff @(posedge clk_i) begin
    if (wr_en_i[1]) mem_q[r_addr_i] <= r_wdata_i;
    if (wr_en_i[0]) mem_q[l_addr_i] <= l_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      if (rd_en_i[0]) l_rdata_o <= mem_q[l_addr_i];
      if (rd_en_i[1]) r_rdata_o <= mem_q[r_addr_i];
    end
  end
endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int NPORT = 2;

  logic             match;
  logic [NPORT-1:0] ce_v, we_v, lose_v, bin_v, bout_v, wr_v, rd_v;

  assign ce_v  = {r_ce_i, l_ce_i};
  assign we_v  = {r_we_i, l_we_i};
  assign bin_v = {r_busy_i, l_busy_i};

  dparb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .l_ce_i   (l_ce_i),
    .l_addr_i (l_addr_i),
    .r_ce_i   (r_ce_i),
    .r_addr_i (r_addr_i),
    .match_o  (match),
    .l_lose_o (lose_v[0]),
    .r_lose_o (lose_v[1])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dparb_port_gate u_gate (
      .master_i (master_i),
      .lose_i   (lose_v[p]),
      .busy_i   (bin_v[p]),
      .ce_i     (ce_v[p]),
      .we_i     (we_v[p]),
      .busy_o   (bout_v[p]),
      .wr_en_o  (wr_v[p]),
      .rd_en_o  (rd_v[p])
    );
  end

  assign l_busy_o = bout_v[0];
  assign r_busy_o = bout_v[1];

  dparb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_v),
    .rd_en_i   (rd_v),
    .l_addr_i  (l_addr_i),
    .r_addr_i  (r_addr_i),
    .l_wdata_i (l_wdata_i),
    .r_wdata_i (r_wdata_i),
    .l_rdata_o (l_rdata_o),
    .r_rdata_o (r_rdata_o)
  );

  AST_NO_FALSE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !(l_ce_i && r_ce_i && (l_addr_i == r_addr_i))) |-> (!l_busy_o && !r_busy_o)); // R2

  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && l_ce_i && r_ce_i && (l_addr_i == r_addr_i)) |-> (l_busy_o != r_busy_o)); // R3

  AST_SLAVE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !((l_busy_i && wr_v[0]) || (r_busy_i && wr_v[1]))); // R6

  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && match) |-> !(wr_v[0] && wr_v[1])); // R7
endmodule

// File: tb/sim_dual_port_arb_ram.sv
module sim_dual_port_arb_ram;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0, l_bi = 1'b0, r_bi = 1'b0;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] lwd = '0, rwd = '0;
  logic l_bo, r_bo;
  logic [DW-1:0] l_rd, r_rd;

  int checks = 0, errors = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_lrd = '0, e_rrd = '0;
  logic          pl_ce = 1'b0, pr_ce = 1'b0;
  logic [AW-1:0] pla = '0, pra = '0;
  int            own = 0;

  dual_port_arb_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_ce_i(l_ce), .l_we_i(l_we), .l_addr_i(la), .l_wdata_i(lwd),
    .l_busy_i(l_bi), .l_busy_o(l_bo), .l_rdata_o(l_rd),
    .r_ce_i(r_ce), .r_we_i(r_we), .r_addr_i(ra), .r_wdata_i(rwd),
    .r_busy_i(r_bi), .r_busy_o(r_bo), .r_rdata_o(r_rd)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle on both ports; busy judged before the edge, read data after it
  task automatic step(input logic lc, input logic lw, input logic [AW-1:0] a_l, input logic [DW-1:0] d_l,
                      input logic rc, input logic rw, input logic [AW-1:0] a_r, input logic [DW-1:0] d_r,
                      input string tb, input string tr);
    logic ls, rs, mt, held, lb, rb;
    int win;
    @(negedge clk);
    l_ce = lc; l_we = lw; la = a_l; lwd = d_l;
    r_ce = rc; r_we = rw; ra = a_r; rwd = d_r;
    #(CLK_P/2 - 1);
    ls   = pl_ce && lc && (pla == a_l);
    rs   = pr_ce && rc && (pra == a_r);
    mt   = lc && rc && (a_l == a_r);
    held = ((own == 1) && ls) || ((own == 2) && rs);
    win  = held ? own : ((rs && !ls) ? 2 : 1);
    lb   = master ? (mt && win == 2) : l_bi;
    rb   = master ? (mt && win == 1) : r_bi;
    chk(tb, "l_busy", int'(l_bo), int'(lb));
    chk(tb, "r_busy", int'(r_bo), int'(rb));
    if (lc && !lw) e_lrd = m_mem[a_l];
    if (rc && !rw) e_rrd = m_mem[a_r];
    if (rc && rw && !rb) m_mem[a_r] = d_r;
    if (lc && lw && !lb) m_mem[a_l] = d_l;
    own = mt ? win : 0;
    pl_ce = lc; pla = a_l; pr_ce = rc; pra = a_r;
    @(posedge clk);
    #1;
    chk(tr, "l_rdata", int'(l_rd), int'(e_lrd));
    chk(tr, "r_rdata", int'(r_rd), int'(e_rrd));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0, tag, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset l_rdata", int'(l_rd), 0);
    chk("R1", "reset r_rdata", int'(r_rd), 0);
    chk("R1", "reset l_busy", int'(l_bo), 0);
    chk("R1", "reset r_busy", int'(r_bo), 0);
    rst_n = 1'b1;

    // R1: fill from the left, read back from the right
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, 1'b1, AW'(a), DW'(a * 7 + 3), 1'b0, 1'b0, '0, '0, "R1", "R1");
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW'(a), '0, "R1", "R1");

    // R2 R4 R7 R8: every address pair, every read/write mix, fresh contention
    for (int c = 0; c < 4; c++)
      for (int x = 0; x < DEPTH; x++)
        for (int y = 0; y < DEPTH; y++) begin
          step(1'b1, c[0], AW'(x), DW'(x * 13 + c * 29 + 7),
               1'b1, c[1], AW'(y), ~DW'(y * 13 + c * 29 + 7),
               (x == y) ? "R4" : "R2", "R8");
          idle("R2");
        end

    // R4 R3 R7: right arrives first, left's write must be blocked
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW'(5), '0, "R4", "R1");
    step(1'b1, 1'b1, AW'(5), 8'hA5, 1'b1, 1'b0, AW'(5), '0, "R4", "R7");
    step(1'b1, 1'b0, AW'(5), '0, 1'b1, 1'b0, AW'(5), '0, "R3", "R7");
    // R5: right releases, left continues alone then keeps the word
    step(1'b1, 1'b0, AW'(5), '0, 1'b0, 1'b0, '0, '0, "R5", "R5");
    step(1'b1, 1'b0, AW'(5), '0, 1'b1, 1'b1, AW'(5), 8'h3C, "R5", "R7");
    step(1'b1, 1'b1, AW'(5), 8'h77, 1'b1, 1'b1, AW'(5), 8'h3C, "R5", "R7");
    // R5: left moves away and back; right now already there and wins
    step(1'b1, 1'b0, AW'(6), '0, 1'b1, 1'b1, AW'(5), 8'h3C, "R5", "R5");
    step(1'b1, 1'b1, AW'(5), 8'h11, 1'b1, 1'b0, AW'(5), '0, "R5", "R8");
    step(1'b1, 1'b0, AW'(5), '0, 1'b0, 1'b0, '0, '0, "R7", "R7");
    idle("R5");

    // R6 R9: slave mode follows external busy
    master = 1'b0;
    l_bi = 1'b1;
    step(1'b1, 1'b1, AW'(3), 8'hE1, 1'b1, 1'b0, AW'(3), '0, "R6", "R8");
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW'(3), '0, "R6", "R6");
    l_bi = 1'b0; r_bi = 1'b1;
    step(1'b1, 1'b0, AW'(4), '0, 1'b1, 1'b1, AW'(4), 8'h5A, "R6", "R6");
    step(1'b1, 1'b0, AW'(4), '0, 1'b0, 1'b0, '0, '0, "R6", "R6");
    r_bi = 1'b0;
    step(1'b1, 1'b1, AW'(9), 8'hC3, 1'b1, 1'b1, AW'(9), 8'h3C, "R9", "R9");
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW'(9), '0, "R9", "R9");
    l_bi = 1'b1; r_bi = 1'b1;
    step(1'b1, 1'b1, AW'(10), 8'h01, 1'b1, 1'b1, AW'(11), 8'h02, "R6", "R6");
    l_bi = 1'b0; r_bi = 1'b0;
    idle("R6");
    master = 1'b1;
    idle("R2");

    // R7: final read-out of every word
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, 1'b0, AW'(a), '0, 1'b0, 1'b0, '0, '0, "R7", "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule